// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Holding Queue

This block receives asynchronous serial frames. The line is sampled on a tick that runs at sixteen times the bit rate. The block times each bit from the falling edge that starts the frame. It settles each bit level by a two-of-three vote over three ticks near the middle of the bit. Data bits collect in a shift register. When the stop bit has been judged, the frame enters a two-entry queue. Each queue entry stores its data byte, an optional ninth bit, and a flag that records a bad stop bit.

Software reads the status outputs first, because they describe the oldest entry. It then pulses the read strobe, which removes that entry, and the next entry's data and status appear. A third frame that arrives while both entries are full raises a sticky overrun flag. While that flag is set, no frame is stored. Clearing the enable input is the only way to clear the flag.

Top module: `oversampled_rx`

## Requirements
- R1: With `rx_en` high and `nine_bit` low, a frame is received and its byte appears on `rd_data`. The frame is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit, each bit lasting 16 ticks.
- R2: A bit level is the majority of the synchronised line on the 7th, 8th and 9th tick of that bit. A single disagreeing sample leaves the bit unchanged. Two disagreeing samples flip it. Samples outside those three ticks have no effect.
- R3: A falling edge starts a frame only if the start bit's majority sample is low. Otherwise the receiver returns to idle, stores nothing, and accepts the next frame normally.
- R4: With `nine_bit` high at the start edge, 9 data bits are received and the ninth appears on `rd_bit9`. In 8-bit mode `rd_bit9` reads 0.
- R5: A frame whose stop-bit majority is low is still stored, with `rd_ferr` set to 1 for that entry. A frame with a high stop bit stores `rd_ferr` as 0.
- R6: The queue holds two entries and presents the oldest entry first. Each entry keeps its own `rd_bit9` and `rd_ferr`, and a read shows the next entry's status.
- R7: `data_ready` is 1 exactly while the queue holds at least one entry. A read strobe while the queue is empty is ignored.
- R8: When a stop bit is judged while both entries are full and no read occurs in that cycle, `overrun` becomes 1. That frame is discarded, and the queue contents are unchanged.
- R9: While `overrun` is 1, no frame is stored, even if the queue has room. Driving `rx_en` low clears `overrun`, and reception then resumes.
- R10: `irq` is 1 exactly when `data_ready` and `irq_en` are both 1.
- R11: While `rx_en` is low, frames on the line are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receive enable; low resets the receiver and clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rd_stb | input | 1 | One-cycle strobe that removes the oldest entry |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_bit9 | output | 1 | Ninth bit of the oldest entry |
| rd_ferr | output | 1 | Bad-stop-bit flag of the oldest entry |
| overrun | output | 1 | Sticky overrun flag |
| irq_en | input | 1 | Interrupt enable |
| data_ready | output | 1 | Queue is not empty |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `rd_stb` and `tick16` are single-cycle pulses on the clock.
- Ticks are at least two clocks apart.
- `rx_en` changes only on the clock.

The overrun and queue-depth properties also assume that a read and a stop-bit decision in the same cycle count as freeing an entry.

The bench drives every input on the falling clock edge and produces a tick every four clocks. It changes the line only just after a tick. This keeps each corrupted sample inside one known tick window, so the vote outcome can be predicted.

// File: rtl/oversampled_rx.sv
module oversampled_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rd_ferr,
  output logic       overrun,
  input  logic       irq_en,
  output logic       data_ready,
  output logic       irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] SFIRST = CW'(OVS/2 - 2);
  localparam logic [CW-1:0] SLAST  = CW'(OVS/2);
  localparam logic [CW-1:0] CLAST  = CW'(OVS - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;
  st_t st;

  logic          rx_m, rx_s, rx_p;
  logic [CW-1:0] cnt;
  logic [1:0]    votes;
  logic [3:0]    idx;
  logic          mode9;
  logic [8:0]    sr;
  logic [9:0]    ent0, ent1;
  logic [1:0]    fill;

  logic in_win, decide, bit_val, push, pop, ovr_set, wr_lo;
  logic [9:0] new_ent;

  assign in_win  = tick16 && cnt >= SFIRST && cnt <= SLAST;
  assign decide  = tick16 && cnt == SLAST;
  assign bit_val = ({1'b0, votes} + {2'b0, rx_s}) >= 3'd2;
  assign pop     = rd_stb && fill != 2'd0;
  assign push    = rx_en && st == STOP && decide && !overrun && (fill != 2'd2 || pop);
  assign ovr_set = rx_en && st == STOP && decide && !overrun && fill == 2'd2 && !pop;
  assign wr_lo   = (fill - {1'b0, pop}) == 2'd0;
  assign new_ent = {~bit_val, mode9 & sr[8], sr[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_p <= 1'b1;
      st <= IDLE; cnt <= '0; votes <= '0; idx <= '0;
      mode9 <= 1'b0; sr <= '0; overrun <= 1'b0;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
      rx_p <= rx_s;
      if (!rx_en) begin
        st <= IDLE;
        overrun <= 1'b0;
      end else if (st == IDLE) begin
        if (rx_p && !rx_s) begin
          st <= START; cnt <= '0; votes <= '0; sr <= '0; mode9 <= nine_bit;
        end
      end else if (tick16) begin
        cnt <= (cnt == CLAST) ? '0 : cnt + 1'b1;
        if (decide) begin
          votes <= '0;
          case (st)
            START: if (bit_val) st <= IDLE;
                   else begin st <= DATA; idx <= '0; end
            DATA: begin
              sr[idx] <= bit_val;
              idx <= idx + 4'd1;
              if (idx == (mode9 ? 4'd8 : 4'd7)) st <= STOP;
            end
            default: begin
              st <= IDLE;
              if (ovr_set) overrun <= 1'b1;
            end
          endcase
        end else if (in_win && rx_s) begin
          votes <= votes + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent0 <= '0; ent1 <= '0; fill <= '0;
    end else begin
      if (pop) ent0 <= ent1;
      if (push) begin
        if (wr_lo) ent0 <= new_ent;
        else       ent1 <= new_ent;
      end
      fill <= fill + {1'b0, push} - {1'b0, pop};
    end
  end

  assign rd_data    = ent0[7:0];
  assign rd_bit9    = ent0[8];
  assign rd_ferr    = ent0[9];
  assign data_ready = fill != 2'd0;
  assign irq        = data_ready & irq_en;
endmodule

// File: rtl/oversampled_rx_chk.sv
module oversampled_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_stb,
  input logic       irq_en,
  input logic       irq,
  input logic       data_ready,
  input logic       overrun,
  input logic [1:0] fill
);
  assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && irq_en) |-> irq);
  assert_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 2'd2);
  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == 2'd0 && rd_stb) |=> fill <= 2'd1);
  assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(rd_stb));
  assert_ovr_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fill) == 2'd2);
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);
  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);
  assert_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> fill <= $past(fill));
endmodule

bind oversampled_rx oversampled_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb), .irq_en(irq_en),
  .irq(irq), .data_ready(data_ready), .overrun(overrun), .fill(fill)
);

// File: tb/oversampled_rx_tb.sv
module oversampled_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, rx_en = 1'b0;
  logic nine_bit = 1'b0, rd_stb = 1'b0, irq_en = 1'b0;
  logic [1:0] tdiv = '0;
  logic tick16;
  logic [7:0] rd_data;
  logic rd_bit9, rd_ferr, overrun, data_ready, irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd0);

  oversampled_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16), .rx_en(rx_en),
    .nine_bit(nine_bit), .rd_stb(rd_stb), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rd_ferr(rd_ferr), .overrun(overrun), .irq_en(irq_en),
    .data_ready(data_ready), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl);
    rx_in = lvl;
    do @(posedge clk); while (!tick16);
    @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input logic stopv,
                      input int nbit, input logic [15:0] mask);
    int nb;
    nb = nine ? 9 : 8;
    for (int k = 0; k < 16; k++) hold(1'b0);
    for (int i = 0; i < nb; i++)
      for (int k = 0; k < 16; k++) hold((i == nbit && mask[k]) ? ~d[i] : d[i]);
    for (int k = 0; k < 16; k++) hold(stopv);
    for (int k = 0; k < 16; k++) hold(1'b1);
  endtask

  task automatic pop_one;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_head(input logic [7:0] d, input logic b9, input logic fe, input string req);
    chk(data_ready == 1'b1, req, data_ready, 1);
    chk(rd_data == d, req, rd_data, d);
    chk(rd_bit9 == b9, req, rd_bit9, b9);
    chk(rd_ferr == fe, req, rd_ferr, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1); hold(1'b1);
    chk(data_ready == 1'b0, "R7 reset", data_ready, 0);
    chk(irq == 1'b0, "R10 reset", irq, 0);
    chk(overrun == 1'b0, "R9 reset", overrun, 0);

    send(9'h05A, 1'b0, 1'b1, -1, 16'h0);
    chk(data_ready == 1'b0, "R11 disabled", data_ready, 0);
    rx_en = 1'b1;
    hold(1'b1);

    for (int i = 0; i < 32; i++) begin
      v = 9'((i * 29 + 3) % 256);
      send(v, 1'b0, 1'b1, -1, 16'h0);
      expect_head(v[7:0], 1'b0, 1'b0, "R1 R4 byte sweep");
      pop_one();
      chk(data_ready == 1'b0, "R7 drained", data_ready, 0);
    end

    nine_bit = 1'b1;
    for (int i = 0; i < 18; i++) begin
      v = (i < 9) ? (9'd1 << i) : ~(9'd1 << (i - 9));
      send(v, 1'b1, 1'b1, -1, 16'h0);
      expect_head(v[7:0], v[8], 1'b0, "R4 nine-bit walk");
      pop_one();
    end
    nine_bit = 1'b0;

    send(9'h000, 1'b0, 1'b1, 3, 16'h0080);
    expect_head(8'h00, 1'b0, 1'b0, "R2 middle sample");  pop_one();
    send(9'h000, 1'b0, 1'b1, 3, 16'h0040);
    expect_head(8'h00, 1'b0, 1'b0, "R2 first sample");   pop_one();
    send(9'h000, 1'b0, 1'b1, 3, 16'h0100);
    expect_head(8'h00, 1'b0, 1'b0, "R2 last sample");    pop_one();
    send(9'h000, 1'b0, 1'b1, 3, 16'h0180);
    expect_head(8'h08, 1'b0, 1'b0, "R2 two samples");    pop_one();
    send(9'h000, 1'b0, 1'b1, 5, 16'h0220);
    expect_head(8'h00, 1'b0, 1'b0, "R2 outside window"); pop_one();
    send(9'h0FF, 1'b0, 1'b1, 0, 16'h01C0);
    expect_head(8'hFE, 1'b0, 1'b0, "R2 three samples");  pop_one();

    for (int k = 0; k < 7; k++) hold(1'b0);
    for (int k = 0; k < 40; k++) hold(1'b1);
    chk(data_ready == 1'b0, "R3 start rejected", data_ready, 0);
    send(9'h03C, 1'b0, 1'b1, -1, 16'h0);
    expect_head(8'h3C, 1'b0, 1'b0, "R3 after reject");   pop_one();

    pop_one();
    chk(data_ready == 1'b0, "R7 empty read", data_ready, 0);
    send(9'h011, 1'b0, 1'b1, -1, 16'h0);
    expect_head(8'h11, 1'b0, 1'b0, "R7 after empty read");
    pop_one();
    chk(data_ready == 1'b0, "R7 one entry", data_ready, 0);

    nine_bit = 1'b1;
    send(9'h1A5, 1'b1, 1'b0, -1, 16'h0);
    send(9'h05A, 1'b1, 1'b1, -1, 16'h0);
    chk(irq == 1'b0, "R10 masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 enabled", irq, 1);
    expect_head(8'hA5, 1'b1, 1'b1, "R5 R6 first entry");
    pop_one();
    expect_head(8'h5A, 1'b0, 1'b0, "R6 second entry");
    pop_one();
    chk(data_ready == 1'b0, "R7 emptied", data_ready, 0);
    chk(irq == 1'b0, "R10 emptied", irq, 0);
    irq_en = 1'b0;
    nine_bit = 1'b0;

    send(9'h001, 1'b0, 1'b1, -1, 16'h0);
    send(9'h002, 1'b0, 1'b1, -1, 16'h0);
    chk(overrun == 1'b0, "R8 full no overrun", overrun, 0);
    send(9'h003, 1'b0, 1'b1, -1, 16'h0);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    expect_head(8'h01, 1'b0, 1'b0, "R8 head kept");   pop_one();
    expect_head(8'h02, 1'b0, 1'b0, "R8 second kept"); pop_one();
    chk(data_ready == 1'b0, "R8 third discarded", data_ready, 0);

    send(9'h004, 1'b0, 1'b1, -1, 16'h0);
    chk(data_ready == 1'b0, "R9 blocked", data_ready, 0);
    chk(overrun == 1'b1, "R9 sticky", overrun, 1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(overrun == 1'b0, "R9 cleared", overrun, 0);
    rx_en = 1'b1;
    hold(1'b1);
    send(9'h005, 1'b0, 1'b1, -1, 16'h0);
    expect_head(8'h05, 1'b0, 1'b0, "R9 resumed");
    pop_one();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule